// File: doc/BRIEF.md
# Single-Wire Sensor Bus Slave Transaction Engine

This block is the slave-side protocol engine for a single-wire register-access bus. A physical-layer front end, which is not part of this block, turns line activity into a start strobe and a stream of one-cycle bit-slot strobes. On a received slot it also delivers the bit value. On a slot that the slave owns, it puts the engine's transmit bit on the wire. The engine parses each frame. It matches the device number against a strapped address and decodes the register address and direction. It then shifts data in or out most-significant bit first, and checks or generates even parity.

On a write, the engine checks the parity the master sent and answers with an acknowledge bit. The register write is committed only when that acknowledge is positive. On a read, the engine fetches the register through a combinational read port, sends the data and a parity bit, and then waits for the master's acknowledge. Any transaction that ends without a positive acknowledge sets a sticky bus-error flag and raises an attention request. The attention request stays up until the next start strobe. The engine never repeats a transaction by itself.

Top module: `sbus_slave_engine`

## Requirements
- R1: A frame is a start strobe followed by bit slots carrying a 3-bit device number, a 7-bit register address (both MSB first) and a direction bit, where 1 means read and 0 means write.
- R2: When the device number equals `dev_strap_i`, the engine responds. For any device number other than the strap or 000, it stays passive until the next start: `tx_drive_o` stays low and no register write occurs.
- R3: Device number 000 is the broadcast number. A broadcast read is ignored. A broadcast write is accepted only when the address equals `CTRL_ADDR`; to any other address it is ignored.
- R4: Bit `a` of `WIDE_MAP` selects a 16-bit data field for address `a` when 1, and an 8-bit field when 0. A narrow field uses bits 7:0 of the register word.
- R5: On an accepted read, the engine drives (`tx_drive_o`=1) the data bits MSB first and then one parity bit. The parity bit makes the count of ones over device number, address, direction bit, data and parity come out even.
- R6: On an accepted write, the engine drives one acknowledge bit after the master's parity bit. The bit is 1 when the received parity is even and 0 otherwise. `reg_we_o` pulses for exactly one cycle, during the acknowledge slot, only when the acknowledge is 1. `reg_wdata_o` is zero-extended for narrow fields.
- R7: `ber_o` is set by the clock edge that ends an acknowledge slot carrying a 0. This covers a 0 sent by the master after a read and a 0 sent by the engine after a write.
- R8: `attn_o` rises on the same edge as the failure that sets `ber_o`. It stays high until a start strobe and is low in the cycle after that strobe.
- R9: `ber_o` is sticky and resets to 0. A positively acknowledged write of a value with bit 0 set to address `STATUS_ADDR` clears it. A read of `STATUS_ADDR` returns an 8-bit field with `ber_o` in bit 0 and zeros elsewhere.
- R10: A start strobe in the middle of a frame abandons it. `tx_drive_o` is low in the next cycle, no write is committed, and the following slots are parsed as a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_strap_i | input | 3 | Strapped device number of this slave |
| start_i | input | 1 | One-cycle start-of-frame strobe |
| slot_i | input | 1 | One-cycle strobe marking the end of a bit slot |
| rx_bit_i | input | 1 | Received bit value, qualified by `slot_i` |
| tx_drive_o | output | 1 | Engine owns the current bit slot |
| tx_bit_o | output | 1 | Bit to put on the line while `tx_drive_o` is high |
| reg_addr_o | output | 7 | Register address to the register file |
| reg_rdata_i | input | 16 | Combinational read data for `reg_addr_o` |
| reg_we_o | output | 1 | One-cycle register write enable |
| reg_wdata_o | output | 16 | Register write data |
| ber_o | output | 1 | Sticky bus-error flag |
| attn_o | output | 1 | Attention request |

## Verification
A bit the engine drives is set up by the edge that ends the slot before it. The bench therefore samples `tx_bit_o` at the falling edge inside the slot that carries it, and pops the expected bit from a queue at that moment. The bench models the register file as memory, so `reg_we_o` is combinational within the acknowledge slot and is compared at the same falling edge. `ber_o` and `attn_o` change on the edge that closes the failing slot, and the bench reads them one time unit after that edge. At the end, the bench checks that no expected bit or write is left unconsumed and that nothing appeared without being expected.

// File: rtl/sbus_pkg.sv
// Package: shared types for the single-wire bus slave engine.
// Assumes: one frame is parsed at a time; states are ordered as a frame runs.
package sbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_RW,
        ST_WDATA,
        ST_WPAR,
        ST_WACK,
        ST_RDATA,
        ST_RPAR,
        ST_RACK
    } sbus_state_e;

endpackage

// File: rtl/sbus_hdr_decode.sv
// Module: sbus_hdr_decode
// Decides, from header fields, whether this slave takes part in a frame.
// Assumes: dev_full_i holds the complete device number in the slot where
// its last bit arrives; bcast_i and addr_i are stable when rw_i is judged.
module sbus_hdr_decode #(
    parameter int unsigned          DEV_W     = 3,
    parameter int unsigned          ADDR_W    = 7,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = '0
) (
    input  logic [DEV_W-1:0]  dev_full_i,
    input  logic [DEV_W-1:0]  strap_i,
    input  logic              bcast_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rw_i,
    output logic              dev_ok_o,
    output logic              dev_bcast_o,
    output logic              rw_accept_o
);

    // Device match: own strap or the broadcast number.
    always_comb begin
        dev_bcast_o = (dev_full_i == '0);
        dev_ok_o    = (dev_full_i == strap_i) || dev_bcast_o;
    end

    // Broadcast frames are only kept for writes to the control register.
    always_comb begin
        rw_accept_o = !bcast_i || (!rw_i && (addr_i == CTRL_ADDR));
    end

endmodule

// File: rtl/sbus_shifter.sv
// Module: sbus_shifter
// Data shift register shared by read and write data, plus running parity.
// Assumes: load and shift are never requested in the same cycle; clear_i
// restarts the parity at each frame start.
module sbus_shifter #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              shift_i,
    input  logic              in_bit_i,
    input  logic              fold_i,
    input  logic              fold_bit_i,
    output logic [DATA_W-1:0] data_o,
    output logic              msb_o,
    output logic              par_o
);

    logic [DATA_W-1:0] data_q;
    logic              par_q;

    // Shift register: parallel load for reads, serial shift for both directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_i) begin
            data_q <= load_val_i;
        end else if (shift_i) begin
            data_q <= {data_q[DATA_W-2:0], in_bit_i};
        end
    end

    // Running XOR of every frame bit folded in so far.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            par_q <= 1'b0;
        end else if (fold_i) begin
            par_q <= par_q ^ fold_bit_i;
        end
    end

    assign data_o = data_q;
    assign msb_o  = data_q[DATA_W-1];
    assign par_o  = par_q;

endmodule

// File: rtl/sbus_err_status.sv
// Module: sbus_err_status
// Holds the sticky bus-error flag and the attention request.
// Assumes: fail_i and clr_i are never high together, since a failure
// and a positive acknowledge cannot happen in the same slot.
module sbus_err_status (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic clr_i,
    input  logic start_i,
    output logic ber_o,
    output logic attn_o
);

    // Sticky error: set by a failed acknowledge, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ber_o <= 1'b0;
        end else if (fail_i) begin
            ber_o <= 1'b1;
        end else if (clr_i) begin
            ber_o <= 1'b0;
        end
    end

    // Attention: raised by a failure, held until the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attn_o <= 1'b0;
        end else if (fail_i) begin
            attn_o <= 1'b1;
        end else if (start_i) begin
            attn_o <= 1'b0;
        end
    end

endmodule

// File: rtl/sbus_slave_engine.sv
// Module: sbus_slave_engine (top)
// Slave transaction engine for a single-wire register-access bus: parses
// the header, moves data MSB first with even parity, handles acknowledge,
// and keeps a sticky error flag with an attention request.
// Assumes: slot_i and start_i are one-cycle strobes; reg_rdata_i is a
// combinational function of reg_addr_o; STATUS_ADDR and CTRL_ADDR are
// narrow in WIDE_MAP.
module sbus_slave_engine
    import sbus_pkg::*;
#(
    parameter int unsigned             DEV_W       = 3,
    parameter int unsigned             ADDR_W      = 7,
    parameter int unsigned             DATA_W      = 16,
    parameter int unsigned             NARROW_W    = 8,
    parameter logic [ADDR_W-1:0]       CTRL_ADDR   = 7'h00,
    parameter logic [ADDR_W-1:0]       STATUS_ADDR = 7'h01,
    parameter logic [(1<<ADDR_W)-1:0]  WIDE_MAP    = {{64{1'b1}}, {64{1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_strap_i,
    input  logic              start_i,
    input  logic              slot_i,
    input  logic              rx_bit_i,
    output logic              tx_drive_o,
    output logic              tx_bit_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              reg_we_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              ber_o,
    output logic              attn_o
);

    localparam int unsigned MAX_FIELD = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int unsigned CNT_W     = $clog2(MAX_FIELD + 1);
    localparam int unsigned PAD_W     = DATA_W - NARROW_W;

    sbus_state_e       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] addr_q;
    logic              bcast_q;
    logic              ok_q;

    logic              take;
    logic [DEV_W-1:0]  dev_full;
    logic              dev_ok, dev_bcast, rw_accept;
    logic              wide;
    logic [CNT_W-1:0]  last_idx;
    logic              is_status;
    logic [DATA_W-1:0] rd_raw, rd_load;
    logic              sh_load, sh_shift, sh_fold, sh_fold_bit;
    logic [DATA_W-1:0] sh_data;
    logic              sh_msb, par;
    logic              fail, st_clr, ack_slot_ok;

    // Slot accepted only when no start strobe overrides it.
    assign take      = slot_i && !start_i;
    assign dev_full  = {dev_q[DEV_W-2:0], rx_bit_i};
    assign wide      = WIDE_MAP[addr_q];
    assign last_idx  = wide ? CNT_W'(DATA_W - 1) : CNT_W'(NARROW_W - 1);
    assign is_status = (addr_q == STATUS_ADDR);

    sbus_hdr_decode #(
        .DEV_W     (DEV_W),
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_hdr (
        .dev_full_i  (dev_full),
        .strap_i     (dev_strap_i),
        .bcast_i     (bcast_q),
        .addr_i      (addr_q),
        .rw_i        (rx_bit_i),
        .dev_ok_o    (dev_ok),
        .dev_bcast_o (dev_bcast),
        .rw_accept_o (rw_accept)
    );

    // Read value: status word from this block or the register file, left-aligned when narrow.
    always_comb begin
        rd_raw  = is_status ? {{(DATA_W-1){1'b0}}, ber_o} : reg_rdata_i;
        rd_load = wide ? rd_raw : (rd_raw << PAD_W);
    end

    // Shifter controls: fold header and data bits into parity, shift data fields.
    always_comb begin
        sh_load     = take && (state_q == ST_RW) && rx_bit_i && rw_accept;
        sh_shift    = take && ((state_q == ST_WDATA) || (state_q == ST_RDATA));
        sh_fold     = take && ((state_q == ST_DEV) || (state_q == ST_ADDR) ||
                               (state_q == ST_RW)  || (state_q == ST_WDATA) ||
                               (state_q == ST_RDATA));
        sh_fold_bit = (state_q == ST_RDATA) ? sh_msb : rx_bit_i;
    end

    sbus_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .load_i     (sh_load),
        .load_val_i (rd_load),
        .shift_i    (sh_shift),
        .in_bit_i   (rx_bit_i),
        .fold_i     (sh_fold),
        .fold_bit_i (sh_fold_bit),
        .data_o     (sh_data),
        .msb_o      (sh_msb),
        .par_o      (par)
    );

    // Frame sequencer: walks header, data, parity and acknowledge slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dev_q   <= '0;
            addr_q  <= '0;
            bcast_q <= 1'b0;
            ok_q    <= 1'b0;
        end else if (start_i) begin
            state_q <= ST_DEV;
            cnt_q   <= '0;
            bcast_q <= 1'b0;
            ok_q    <= 1'b0;
        end else if (slot_i) begin
            case (state_q)
                ST_DEV: begin
                    dev_q <= dev_full;
                    if (cnt_q == CNT_W'(DEV_W - 1)) begin
                        cnt_q   <= '0;
                        bcast_q <= dev_bcast;
                        state_q <= dev_ok ? ST_ADDR : ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ADDR: begin
                    addr_q <= {addr_q[ADDR_W-2:0], rx_bit_i};
                    if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_RW;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RW: begin
                    cnt_q <= '0;
                    if (!rw_accept) begin
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= rx_bit_i ? ST_RDATA : ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (cnt_q == last_idx) begin
                        state_q <= ST_WPAR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WPAR: begin
                    ok_q    <= (rx_bit_i == par);
                    state_q <= ST_WACK;
                end
                ST_RDATA: begin
                    if (cnt_q == last_idx) begin
                        state_q <= ST_RPAR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RPAR: state_q <= ST_RACK;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Line output: data, parity or acknowledge in the slots this slave owns.
    always_comb begin
        tx_drive_o = (state_q == ST_RDATA) || (state_q == ST_RPAR) || (state_q == ST_WACK);
        case (state_q)
            ST_RDATA: tx_bit_o = sh_msb;
            ST_RPAR:  tx_bit_o = par;
            ST_WACK:  tx_bit_o = ok_q;
            default:  tx_bit_o = 1'b0;
        endcase
    end

    // Commit, status clear and failure detection in the acknowledge slots.
    always_comb begin
        reg_wdata_o = wide ? sh_data : {{PAD_W{1'b0}}, sh_data[NARROW_W-1:0]};
        ack_slot_ok = take && (state_q == ST_WACK) && ok_q;
        reg_we_o    = ack_slot_ok && !is_status;
        st_clr      = ack_slot_ok && is_status && reg_wdata_o[0];
        fail        = take && (((state_q == ST_RACK) && !rx_bit_i) ||
                               ((state_q == ST_WACK) && !ok_q));
    end

    assign reg_addr_o = addr_q;

    sbus_err_status u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .fail_i  (fail),
        .clr_i   (st_clr),
        .start_i (start_i),
        .ber_o   (ber_o),
        .attn_o  (attn_o)
    );

endmodule

// File: rtl/sbus_slave_engine_chk.sv
// Module: sbus_slave_engine_chk
// Property checker for the slave engine, attached through bind.
// Assumes: observes top-level ports only.
module sbus_slave_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic slot_i,
    input logic tx_drive_o,
    input logic tx_bit_o,
    input logic reg_we_o,
    input logic ber_o,
    input logic attn_o
);

    AST_WE_ONLY_WHEN_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (tx_drive_o && tx_bit_o)); // R6
    AST_ATTN_RISES_WITH_BER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(attn_o) |-> ber_o); // R8
    AST_ATTN_DROPS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !attn_o); // R8
    AST_BER_HOLDS_WITHOUT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ber_o && !slot_i) |=> ber_o); // R9
    AST_START_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !tx_drive_o); // R10
    AST_START_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !reg_we_o); // R10

endmodule

bind sbus_slave_engine sbus_slave_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .slot_i     (slot_i),
    .tx_drive_o (tx_drive_o),
    .tx_bit_o   (tx_bit_o),
    .reg_we_o   (reg_we_o),
    .ber_o      (ber_o),
    .attn_o     (attn_o)
);

// File: tb/sbus_slave_engine_tb.sv
// Scoreboard bench: transaction tasks queue expected line bits and writes,
// a falling-edge monitor pops and compares them as the engine produces them.
module sbus_slave_engine_tb;

    localparam logic [2:0] STRAP  = 3'd5;
    localparam logic [6:0] CTRL   = 7'h00;
    localparam logic [6:0] STATUS = 7'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        slot_i = 1'b0;
    logic        rx_bit_i = 1'b0;
    logic        tx_drive_o, tx_bit_o, reg_we_o, ber_o, attn_o;
    logic [6:0]  reg_addr_o;
    logic [15:0] reg_rdata_i, reg_wdata_o;

    logic [15:0] regs  [128];
    logic [15:0] model [128];
    logic        ber_m = 1'b0;
    logic        attn_m = 1'b0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 0;

    logic        q_tx [$];
    string       q_tag [$];
    logic [6:0]  q_wa [$];
    logic [15:0] q_wd [$];

    always #4 clk = ~clk;

    sbus_slave_engine u_dut (
        .clk(clk), .rst_n(rst_n), .dev_strap_i(STRAP), .start_i(start_i),
        .slot_i(slot_i), .rx_bit_i(rx_bit_i), .tx_drive_o(tx_drive_o),
        .tx_bit_o(tx_bit_o), .reg_addr_o(reg_addr_o), .reg_rdata_i(reg_rdata_i),
        .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o), .ber_o(ber_o), .attn_o(attn_o)
    );

    assign reg_rdata_i = regs[reg_addr_o];

    always @(posedge clk) begin
        if (reg_we_o) regs[reg_addr_o] <= reg_wdata_o;
    end

    task automatic chk(input string tag, input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare driven bits and register writes against the queues.
    always @(negedge clk) begin
        if (rst_n && slot_i && tx_drive_o) begin
            if (q_tx.size() == 0) begin
                chk("R2", 1'b0, "unexpected line drive", 32'(tx_bit_o), 32'hX);
            end else begin
                logic  b;
                string t;
                b = q_tx.pop_front();
                t = q_tag.pop_front();
                chk(t, tx_bit_o == b, "driven bit", 32'(tx_bit_o), 32'(b));
            end
        end
        if (rst_n && reg_we_o) begin
            if (q_wa.size() == 0) begin
                chk("R2", 1'b0, "unexpected register write", 32'(reg_addr_o), 32'hX);
            end else begin
                logic [6:0]  a;
                logic [15:0] d;
                a = q_wa.pop_front();
                d = q_wd.pop_front();
                chk("R6", reg_addr_o == a, "write address", 32'(reg_addr_o), 32'(a));
                chk("R6", reg_wdata_o == d, "write data", 32'(reg_wdata_o), 32'(d));
            end
        end
    end

    task automatic start_pulse();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        attn_m = 1'b0;
    endtask

    task automatic slot(input logic b);
        @(posedge clk); #1 slot_i = 1'b1; rx_bit_i = b;
        @(posedge clk); #1 slot_i = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) slot(v[i]);
    endtask

    // One frame after the start strobe; expectations follow R1..R9.
    task automatic body_txn(input logic [2:0] dev, input logic [6:0] addr, input logic rw,
                            input logic [15:0] data, input logic bad_par, input logic ack_bit);
        logic        wide, resp, par;
        int          w;
        logic [15:0] v;
        wide = addr[6];
        w    = wide ? 16 : 8;
        resp = (dev == STRAP) || ((dev == 3'd0) && !rw && (addr == CTRL));
        par  = (^dev) ^ (^addr) ^ rw;
        send_bits({13'd0, dev}, 3);
        send_bits({9'd0, addr}, 7);
        slot(rw);
        if (rw) begin
            v = (addr == STATUS) ? {15'd0, ber_m} : model[addr];
            for (int i = w - 1; i >= 0; i--) begin
                if (resp) begin q_tx.push_back(v[i]); q_tag.push_back(wide ? "R4" : "R5"); end
                par = par ^ v[i];
                slot(1'b0);
            end
            if (resp) begin q_tx.push_back(par); q_tag.push_back("R5"); end
            slot(1'b0);
            slot(ack_bit);
            if (resp && !ack_bit) begin ber_m = 1'b1; attn_m = 1'b1; end
        end else begin
            v = wide ? data : {8'd0, data[7:0]};
            for (int i = w - 1; i >= 0; i--) begin
                par = par ^ v[i];
                slot(v[i]);
            end
            slot(bad_par ? ~par : par);
            if (resp) begin
                q_tx.push_back(!bad_par); q_tag.push_back("R6");
                if (bad_par) begin
                    ber_m = 1'b1; attn_m = 1'b1;
                end else if (addr == STATUS) begin
                    if (v[0]) ber_m = 1'b0;
                end else begin
                    q_wa.push_back(addr); q_wd.push_back(v); model[addr] = v;
                end
            end
            slot(1'b0);
        end
        chk("R7", ber_o == ber_m, "ber after frame", 32'(ber_o), 32'(ber_m));
        chk("R8", attn_o == attn_m, "attn after frame", 32'(attn_o), 32'(attn_m));
    endtask

    task automatic do_txn(input logic [2:0] dev, input logic [6:0] addr, input logic rw,
                          input logic [15:0] data, input logic bad_par, input logic ack_bit);
        start_pulse();
        body_txn(dev, addr, rw, data, bad_par, ack_bit);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            regs[i]  = 16'(i * 257) ^ 16'h5A3C;
            model[i] = regs[i];
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R9", ber_o == 1'b0, "reset ber", 32'(ber_o), 0);
        chk("R8", attn_o == 1'b0, "reset attn", 32'(attn_o), 0);
        chk("R1", tx_drive_o == 1'b0, "reset drive", 32'(tx_drive_o), 0);

        do_txn(STRAP, 7'h05, 1'b0, 16'h00A7, 1'b0, 1'b1);   // R1 R6 narrow write
        do_txn(STRAP, 7'h05, 1'b1, 16'h0, 1'b0, 1'b1);      // R5 narrow read
        do_txn(STRAP, 7'h45, 1'b0, 16'hBEEF, 1'b0, 1'b1);   // R4 wide write
        do_txn(STRAP, 7'h45, 1'b1, 16'h0, 1'b0, 1'b1);      // R4 wide read
        do_txn(STRAP, 7'h46, 1'b1, 16'h0, 1'b0, 1'b1);      // R4 initial value read
        do_txn(STRAP, 7'h07, 1'b0, 16'h0033, 1'b1, 1'b1);   // R6 R7 bad parity
        chk("R6", regs[7] == model[7], "no commit on nak", 32'(regs[7]), 32'(model[7]));
        start_pulse();
        @(negedge clk);
        chk("R8", attn_o == 1'b0, "attn after start", 32'(attn_o), 0);
        body_txn(STRAP, STATUS, 1'b1, 16'h0, 1'b0, 1'b1);   // R9 status reads 1
        do_txn(STRAP, STATUS, 1'b0, 16'h0001, 1'b0, 1'b1);  // R9 clear
        chk("R9", ber_o == 1'b0, "ber cleared", 32'(ber_o), 0);
        do_txn(STRAP, 7'h05, 1'b1, 16'h0, 1'b0, 1'b0);      // R7 read nak by master
        do_txn(STRAP, STATUS, 1'b0, 16'h0000, 1'b0, 1'b1);  // R9 write of 0 keeps ber
        chk("R9", ber_o == 1'b1, "ber sticky", 32'(ber_o), 1);
        do_txn(STRAP, STATUS, 1'b0, 16'h00FF, 1'b0, 1'b1);  // R9 clear again
        do_txn(3'd3, 7'h05, 1'b0, 16'h0011, 1'b0, 1'b1);    // R2 other device
        chk("R2", regs[5] == model[5], "other device ignored", 32'(regs[5]), 32'(model[5]));
        do_txn(3'd0, CTRL, 1'b1, 16'h0, 1'b0, 1'b0);        // R3 broadcast read ignored
        chk("R3", ber_o == 1'b0, "broadcast read no error", 32'(ber_o), 0);
        do_txn(3'd0, CTRL, 1'b0, 16'h0096, 1'b0, 1'b1);     // R3 broadcast ctrl write
        chk("R3", regs[0] == 16'h0096, "broadcast ctrl write", 32'(regs[0]), 32'h96);
        do_txn(3'd0, 7'h05, 1'b0, 16'h0077, 1'b0, 1'b1);    // R3 broadcast other ignored
        chk("R3", regs[5] == model[5], "broadcast other ignored", 32'(regs[5]), 32'(model[5]));

        // R10: abort a wide read after two data bits, then run a full write.
        start_pulse();
        send_bits({13'd0, STRAP}, 3);
        send_bits(16'h0045, 7);
        slot(1'b1);
        q_tx.push_back(model[7'h45][15]); q_tag.push_back("R10");
        q_tx.push_back(model[7'h45][14]); q_tag.push_back("R10");
        slot(1'b0);
        slot(1'b0);
        start_pulse();
        chk("R10", tx_drive_o == 1'b0, "line released on start", 32'(tx_drive_o), 0);
        body_txn(STRAP, 7'h05, 1'b0, 16'h003C, 1'b0, 1'b1);
        do_txn(STRAP, 7'h05, 1'b1, 16'h0, 1'b0, 1'b1);      // R10 new frame parsed

        repeat (2) @(posedge clk);
        chk("R2", q_tx.size() == 0, "pending driven bits", 32'(q_tx.size()), 0);
        chk("R6", q_wa.size() == 0, "pending writes", 32'(q_wa.size()), 0);
        summary();
    end

endmodule